// File: doc/BRIEF.md
# Power Mode Control Register

This block is the power configuration register of a small microcontroller. It sits on the special-function-register (SFR) bus at address 87h. It holds six live bits: two general-purpose software flags, two serial-port option bits that are passed to the UART, and two mode requests.

The mode requests are Idle and Power-down. The block turns them into three clock-enable outputs. Idle stops only the CPU clock. Power-down stops the oscillator and with it every clock. Power-down wins when both requests are set.

Both mode bits clear on the next clock edge after an interrupt wake request. The reset pin clears the whole register asynchronously. Because of that, a stopped oscillator restarts with no clock edge needed.

The SFR bit layout is fixed by the software that drives it:

| Bit | Meaning |
|-----|---------|
| 7 | baud doubling |
| 6 | framing-error select |
| 5, 4 | reserved, read as 0 |
| 3 | general-purpose flag 1 |
| 2 | general-purpose flag 0 |
| 1 | Power-down request |
| 0 | Idle request |

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst_pin` is high, the register is 00h. In that state `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, and `baud_dbl` and `fe_sel` are 0.
- R2: A rising clock edge with `sfr_wr`=1 and `sfr_addr`=87h loads bits 7, 6, 3, 2, 1 and 0 from `sfr_wdata`.
- R3: A write to any other address leaves the register unchanged.
- R4: Bits 5 and 4 always read as 0, whatever value was written to them.
- R5: With `sfr_addr`=87h, `sfr_rdata` shows the register in the same cycle, with no clock edge. With any other address, `sfr_rdata` is 00h.
- R6: With bit 0 set and bit 1 clear, `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_en`=1.
- R7: With bit 1 set, all three enables are 0, whatever the value of bit 0.
- R8: `irq_wake`=1 at a rising edge clears bits 1 and 0 after that edge. The other bits keep their value, or take the value of a write made in the same cycle. A write made in the same cycle cannot set bit 1 or bit 0.
- R9: Raising `rst_pin` clears bit 1 and sets `osc_en` to 1 without waiting for a clock edge.
- R10: `baud_dbl` follows bit 7 and `fe_sel` follows bit 6.
- R11: Bits 3 and 2 have no effect on any output other than `sfr_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | free-running clock |
| rst_pin | input | 1 | asynchronous reset, active high |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, 00h when not addressed |
| irq_wake | input | 1 | interrupt taken, clears the mode bits |
| baud_dbl | output | 1 | double baud rate to the UART |
| fe_sel | output | 1 | framing-error select to the UART |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | peripheral clock enable |
| osc_en | output | 1 | oscillator enable |

## Verification
The bench sets Idle and Power-down together and expects the outputs of Power-down alone. A design that let Idle win would keep the oscillator running.

It asserts `irq_wake` in the same cycle as a write that sets both mode bits. A design that gave the write priority would stay asleep after the interrupt.

It raises `rst_pin` between clock edges and checks `osc_en` before the next edge. A synchronous clear would leave the chip stopped for good.

Writes of all-ones show whether the reserved bits stay 0. Writes to nearby addresses show whether the address decode is too loose.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  localparam int DATA_W = 8;
  localparam int B_BAUD = 7;
  localparam int B_FSEL = 6;
  localparam int B_GF1  = 3;
  localparam int B_GF0  = 2;
  localparam int B_PD   = 1;
  localparam int B_IDL  = 0;
  localparam logic [DATA_W-1:0] WR_MASK   = 8'hCF;
  localparam logic [DATA_W-1:0] MODE_MASK = 8'h03;

  function automatic logic [DATA_W-1:0] keep_live(input logic [DATA_W-1:0] d);
    return d & WR_MASK;
  endfunction

  function automatic logic [DATA_W-1:0] drop_modes(input logic [DATA_W-1:0] d);
    return d & ~MODE_MASK;
  endfunction

  function automatic logic cpu_runs(input logic pd, input logic idl);
    return !(pd || idl);
  endfunction

  function automatic logic periph_runs(input logic pd);
    return !pd;
  endfunction
endpackage

// File: rtl/pmode_store.sv
module pmode_store
  import pmode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wake,
  output logic              wr_hit,
  output logic [DATA_W-1:0] reg_q
);
  logic [DATA_W-1:0] reg_d;

  assign wr_hit = wr && (addr == REG_ADDR);

  always_comb begin
    reg_d = reg_q;
    if (wr_hit) reg_d = keep_live(wdata);
    if (wake)   reg_d = drop_modes(reg_d);
  end

  always_ff @(posedge clk or posedge rst_pin) begin
    if (rst_pin) reg_q <= '0;
    else         reg_q <= reg_d;
  end
endmodule

// File: rtl/pmode_gate.sv
module pmode_gate
  import pmode_pkg::*;
(
  input  logic pd,
  input  logic idl,
  output logic cpu_en,
  output logic periph_en,
  output logic osc_en
);
  assign cpu_en    = cpu_runs(pd, idl);
  assign periph_en = periph_runs(pd);
  assign osc_en    = periph_runs(pd);
endmodule

// File: rtl/pmode_rdmux.sv
module pmode_rdmux
  import pmode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0] rdata
);
  assign rdata = (addr == REG_ADDR) ? reg_q : '0;
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              irq_wake,
  output logic              baud_dbl,
  output logic              fe_sel,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              osc_en
);
  logic [DATA_W-1:0] reg_q;
  logic              wr_hit;
  logic              pd_q;
  logic              idl_q;

  pmode_store #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_store (
    .clk(clk), .rst_pin(rst_pin), .addr(sfr_addr), .wr(sfr_wr),
    .wdata(sfr_wdata), .wake(irq_wake), .wr_hit(wr_hit), .reg_q(reg_q)
  );

  assign pd_q  = reg_q[B_PD];
  assign idl_q = reg_q[B_IDL];

  pmode_gate u_gate (
    .pd(pd_q), .idl(idl_q), .cpu_en(cpu_clk_en),
    .periph_en(periph_clk_en), .osc_en(osc_en)
  );

  pmode_rdmux #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rd (
    .addr(sfr_addr), .reg_q(reg_q), .rdata(sfr_rdata)
  );

  assign baud_dbl = reg_q[B_BAUD];
  assign fe_sel   = reg_q[B_FSEL];
endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk
  import pmode_pkg::*;
(
  input logic              clk,
  input logic              rst_pin,
  input logic              sfr_wr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic              irq_wake,
  input logic              wr_hit,
  input logic [DATA_W-1:0] reg_q,
  input logic              pd_q,
  input logic              idl_q,
  input logic              cpu_clk_en,
  input logic              periph_clk_en,
  input logic              osc_en
);
  AST_PD_STOPS_ALL: assert property (@(posedge clk) disable iff (rst_pin)
    pd_q |-> (!osc_en && !cpu_clk_en && !periph_clk_en)); // R7

  AST_IDLE_CPU_ONLY: assert property (@(posedge clk) disable iff (rst_pin)
    (idl_q && !pd_q) |-> (!cpu_clk_en && periph_clk_en && osc_en)); // R6

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst_pin)
    irq_wake |=> (!pd_q && !idl_q)); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst_pin)
    reg_q[5:4] == 2'b00); // R4

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst_pin)
    (sfr_wr && !wr_hit && !irq_wake) |=> $stable(reg_q)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst_pin)
    (wr_hit && !irq_wake) |=> (reg_q == ($past(sfr_wdata) & 8'hCF))); // R2
endmodule

bind pmode_ctrl pmode_ctrl_chk u_chk (
  .clk(clk), .rst_pin(rst_pin), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
  .irq_wake(irq_wake), .wr_hit(wr_hit), .reg_q(reg_q), .pd_q(pd_q),
  .idl_q(idl_q), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
  .osc_en(osc_en)
);

// File: tb/pmode_ctrl_tb_top.sv
module pmode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_pin = 1'b1;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       irq_wake = 1'b0;
  logic       baud_dbl, fe_sel, cpu_clk_en, periph_clk_en, osc_en;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmode_ctrl dut_i (
    .clk(clk), .rst_pin(rst_pin), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_wake(irq_wake),
    .baud_dbl(baud_dbl), .fe_sel(fe_sel), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en)
  );

  function automatic logic [7:0] next_model(input logic [7:0] cur, input logic w,
                                            input logic [7:0] a, input logic [7:0] d,
                                            input logic wk);
    logic [7:0] r;
    r = cur;
    if (w && a == 8'h87) r = {d[7:6], 2'b00, d[3:0]};
    if (wk) r = {r[7:2], 2'b00};
    return r;
  endfunction

  function automatic logic [4:0] exp_outs(input logic [7:0] r);
    logic pd, idl;
    pd = r[1];
    idl = r[0];
    return {r[7], r[6], ~(pd | idl), ~pd, ~pd};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    sfr_addr = 8'h87;
    #1;
    chk(req, {24'd0, sfr_rdata}, {24'd0, model});
    chk(req, {27'd0, baud_dbl, fe_sel, cpu_clk_en, periph_clk_en, osc_en},
        {27'd0, exp_outs(model)});
  endtask

  task automatic cycle(input logic w, input logic [7:0] a, input logic [7:0] d,
                       input logic wk, input string req);
    @(negedge clk);
    sfr_wr = w;
    sfr_addr = a;
    sfr_wdata = d;
    irq_wake = wk;
    @(posedge clk);
    model = next_model(model, w, a, d, wk);
    @(negedge clk);
    sfr_wr = 1'b0;
    irq_wake = 1'b0;
    check_state(req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R1: reset state
    #1;
    check_state("R1");
    @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk);
    check_state("R1");

    // R2 R4 R10: all-ones write, reserved bits stay 0, UART bits follow
    cycle(1'b1, 8'h87, 8'hF0, 1'b0, "R4");
    chk("R10", {30'd0, baud_dbl, fe_sel}, 32'd3);
    cycle(1'b1, 8'h87, 8'hFF, 1'b0, "R7");

    // R3: neighbour addresses ignored
    cycle(1'b1, 8'h86, 8'h00, 1'b0, "R3");
    cycle(1'b1, 8'h07, 8'h00, 1'b0, "R3");
    cycle(1'b1, 8'h88, 8'h00, 1'b0, "R3");

    // R5: foreign read gives zero, same-cycle read
    sfr_addr = 8'h86;
    #1;
    chk("R5", {24'd0, sfr_rdata}, 32'd0);
    sfr_addr = 8'h87;
    #1;
    chk("R5", {24'd0, sfr_rdata}, 32'hCF);

    // R6: Idle only
    cycle(1'b1, 8'h87, 8'h01, 1'b0, "R6");
    chk("R6", {29'd0, cpu_clk_en, periph_clk_en, osc_en}, 32'd3);
    // R11: flags with no effect on enables
    cycle(1'b1, 8'h87, 8'h0C, 1'b0, "R11");
    chk("R11", {27'd0, baud_dbl, fe_sel, cpu_clk_en, periph_clk_en, osc_en}, 32'd7);

    // R8: wake beats simultaneous write of mode bits
    cycle(1'b1, 8'h87, 8'hC7, 1'b1, "R8");
    chk("R8", {24'd0, sfr_rdata}, 32'hC4);
    cycle(1'b1, 8'h87, 8'h02, 1'b0, "R7");
    cycle(1'b0, 8'h87, 8'h00, 1'b1, "R8");

    // R9: async reset between edges
    cycle(1'b1, 8'h87, 8'h8B, 1'b0, "R7");
    @(negedge clk);
    #1;
    rst_pin = 1'b1;
    #1;
    model = 8'h00;
    chk("R9", {31'd0, osc_en}, 32'd1);
    chk("R9", {24'd0, sfr_rdata}, 32'd0);
    @(negedge clk);
    rst_pin = 1'b0;

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [1:0] pick;
      pick = 2'($urandom_range(0, 3));
      a = (pick == 0) ? 8'($urandom) : 8'h87;
      cycle(($urandom_range(0, 3) != 0), a, 8'($urandom),
            ($urandom_range(0, 5) == 0), "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule